// File: doc/BRIEF.md
# Serial Packet Frame Transmitter

This block drives one input port of a bit-serial packet switch. A client hands it a 4-bit destination, a payload word and a payload length through a start/ready handshake. The block then plays the frame out on three wires: an active-low frame strobe, an active-low valid strobe and a single data line. It follows the switch's active-low busy signal while it sends the payload.

A frame opens with the destination bits, which go out without any look at busy. A one-cycle marker and three padding cycles follow. The payload is then sent one bit per cycle, but only while the switch reports that it is not busy. The frame strobe rises together with the final payload bit. A done pulse and a mandatory idle gap follow before the next request can be accepted. All pin outputs come from flip-flops, and the reset is synchronous and active high.

Top module: `sertx_top`

## Requirements
- R1: While `rst` is high at a clock edge, the following cycle shows `ready_o`=1, `done_o`=0, `frame_no`=1, `valid_no`=1 and `data_o`=0.
- R2: A request is taken at a rising edge where `start_i` and `ready_o` are both 1. `ready_o` is 0 from the next cycle until the gap has ended. Requests and operand changes while `ready_o` is 0 have no effect on the frame being sent.
- R3: In the four cycles after acceptance, `frame_no`=0, `valid_no`=1 and `data_o` carries destination bits 0, 1, 2, 3 in that order. The value of `busy_ni` has no effect on these cycles.
- R4: Cycle 5 after acceptance shows `data_o`=1 with `valid_no`=1. Cycles 6 to 8 show `data_o`=0 with `valid_no`=1. `frame_no` stays 0 throughout.
- R5: From cycle 9 on, `valid_no` is 0 in a cycle only if `busy_ni` was 1 at the preceding rising edge. The bit shown with `valid_no`=0 is the next untaken payload bit, starting from payload bit 0 and moving upward.
- R6: A payload cycle that follows an edge where `busy_ni` was 0 shows `valid_no`=1, `frame_no`=0 and the same untaken payload bit.
- R7: `frame_no` returns to 1 in the very cycle that shows the last payload bit with `valid_no`=0. Before that cycle it never rises.
- R8: `done_o` is 1 for exactly one cycle, the cycle right after the last payload bit.
- R9: After the last payload bit, `frame_no` stays 1 for at least GAP_CYCLES+1 cycles. If `start_i` is held high, the first destination bit of the next frame appears exactly GAP_CYCLES+2 cycles after the last payload bit.
- R10: While no frame is in progress, `frame_no`=1, `valid_no`=1 and `data_o`=0.
- R11: A length of 0 is sent as 1 bit, and a length above MAX_LEN is sent as MAX_LEN bits.
- R12: Raising `rst` during a frame abandons it: the next cycle shows the idle state of R1, and the next request is sent in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to send a frame |
| dest_i | input | 4 | Destination port number |
| payload_i | input | MAX_LEN | Payload word, bit 0 is sent first |
| len_i | input | $clog2(MAX_LEN+1) | Payload length in bits |
| busy_ni | input | 1 | Switch busy, active low |
| ready_o | output | 1 | A request can be accepted |
| frame_no | output | 1 | Frame strobe, active low |
| valid_no | output | 1 | Payload valid strobe, active low |
| data_o | output | 1 | Serial data line |
| done_o | output | 1 | One-cycle pulse after the frame ends |

## Verification
The bench holds `busy_ni` low during the address and marker cycles. A design that checked busy there would stall the destination bits. It also uses busy patterns that stall in the middle of the payload, which exposes a design that advances to the next bit or drops `valid_no` on a cycle the switch refused. Frames of one bit and of the full length, plus zero and oversized lengths, target off-by-one errors in the frame-end cycle and in the length clamp. With `start_i` held high across a frame, the bench looks for a design that accepts a request early, cuts the gap short or picks up operands changed in mid-frame. A reset in mid-frame checks that nothing of the old frame leaks into the next one.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int ADDR_BITS  = 4;
  localparam int PAD_CYCLES = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_MARK,
    ST_PAD,
    ST_PAY,
    ST_GAP
  } tx_state_e;
endpackage

// File: rtl/sertx_store.sv
module sertx_store #(
  parameter int MAX_LEN = 16,
  parameter int LEN_W   = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 accept,
  input  logic [3:0]           dest_i,
  input  logic [MAX_LEN-1:0]   payload_i,
  input  logic [LEN_W-1:0]     len_i,
  output logic [3:0]           dest_q,
  output logic [MAX_LEN-1:0]   pay_q,
  output logic [LEN_W-1:0]     len_q
);
  logic [LEN_W-1:0] len_c;

  // out-of-range lengths are clamped into 1..MAX_LEN
  always_comb begin
    if (len_i == '0)
      len_c = LEN_W'(1);
    else if (len_i > LEN_W'(MAX_LEN))
      len_c = LEN_W'(MAX_LEN);
    else
      len_c = len_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dest_q <= '0;
      pay_q  <= '0;
      len_q  <= LEN_W'(1);
    end else if (accept) begin
      dest_q <= dest_i;
      pay_q  <= payload_i;
      len_q  <= len_c;
    end
  end
endmodule

// File: rtl/sertx_seq.sv
module sertx_seq
  import sertx_pkg::*;
#(
  parameter int GAP_CYCLES = 1,
  parameter int LEN_W      = 5,
  parameter int CNT_W      = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             busy_ni,
  input  logic [LEN_W-1:0] len_q,
  output tx_state_e        nxt_state,
  output logic [CNT_W-1:0] nxt_idx,
  output logic             nxt_take,
  output logic             nxt_end,
  output logic             accept,
  output logic             last_take,
  output logic             ready_o
);
  tx_state_e        state_q;
  logic [CNT_W-1:0] idx_q;
  logic             take_q;
  logic [CNT_W-1:0] last_idx;

  assign last_idx = CNT_W'(len_q - LEN_W'(1));

  always_comb begin
    nxt_state = state_q;
    nxt_idx   = idx_q;
    nxt_take  = 1'b0;
    accept    = 1'b0;
    last_take = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          accept    = 1'b1;
          nxt_state = ST_ADDR;
          nxt_idx   = '0;
        end
      end
      ST_ADDR: begin
        if (idx_q == CNT_W'(ADDR_BITS - 1)) begin
          nxt_state = ST_MARK;
          nxt_idx   = '0;
        end else begin
          nxt_idx = idx_q + 1'b1;
        end
      end
      ST_MARK: begin
        nxt_state = ST_PAD;
        nxt_idx   = '0;
      end
      ST_PAD: begin
        if (idx_q == CNT_W'(PAD_CYCLES - 1)) begin
          nxt_state = ST_PAY;
          nxt_idx   = '0;
          nxt_take  = busy_ni;
        end else begin
          nxt_idx = idx_q + 1'b1;
        end
      end
      ST_PAY: begin
        if (take_q && idx_q == last_idx) begin
          last_take = 1'b1;
          nxt_state = ST_GAP;
          nxt_idx   = '0;
        end else begin
          if (take_q) nxt_idx = idx_q + 1'b1;
          nxt_take = busy_ni;
        end
      end
      ST_GAP: begin
        if (idx_q == CNT_W'(GAP_CYCLES - 1)) begin
          nxt_state = ST_IDLE;
          nxt_idx   = '0;
        end else begin
          nxt_idx = idx_q + 1'b1;
        end
      end
      default: begin
        nxt_state = ST_IDLE;
        nxt_idx   = '0;
      end
    endcase
  end

  assign nxt_end = nxt_take && (nxt_idx == last_idx);
  assign ready_o = (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      take_q  <= 1'b0;
    end else begin
      state_q <= nxt_state;
      idx_q   <= nxt_idx;
      take_q  <= nxt_take;
    end
  end
endmodule

// File: rtl/sertx_oreg.sv
module sertx_oreg
  import sertx_pkg::*;
#(
  parameter int MAX_LEN = 16,
  parameter int CNT_W   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  tx_state_e          nxt_state,
  input  logic [CNT_W-1:0]   nxt_idx,
  input  logic               nxt_take,
  input  logic               nxt_end,
  input  logic               accept,
  input  logic               dest0_i,
  input  logic [3:0]         dest_q,
  input  logic [MAX_LEN-1:0] pay_q,
  input  logic               last_take,
  output logic               frame_no,
  output logic               valid_no,
  output logic               data_o,
  output logic               done_o
);
  logic f_d, v_d, d_d;
  logic addr_bit, pay_bit;

  assign addr_bit = |(dest_q & (4'(1) << nxt_idx));
  assign pay_bit  = |(pay_q & (MAX_LEN'(1) << nxt_idx));

  always_comb begin
    f_d = 1'b1;
    v_d = 1'b1;
    d_d = 1'b0;
    case (nxt_state)
      ST_ADDR: begin
        f_d = 1'b0;
        d_d = accept ? dest0_i : addr_bit;
      end
      ST_MARK: begin
        f_d = 1'b0;
        d_d = 1'b1;
      end
      ST_PAD: f_d = 1'b0;
      ST_PAY: begin
        f_d = nxt_end;
        v_d = ~nxt_take;
        d_d = pay_bit;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_no <= 1'b1;
      valid_no <= 1'b1;
      data_o   <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      frame_no <= f_d;
      valid_no <= v_d;
      data_o   <= d_d;
      done_o   <= last_take;
    end
  end
endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int MAX_LEN    = 16,
  parameter int GAP_CYCLES = 1,
  localparam int LEN_W     = $clog2(MAX_LEN + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [3:0]         dest_i,
  input  logic [MAX_LEN-1:0] payload_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic               busy_ni,
  output logic               ready_o,
  output logic               frame_no,
  output logic               valid_no,
  output logic               data_o,
  output logic               done_o
);
  localparam int CNT_MAX0 = (MAX_LEN > GAP_CYCLES) ? MAX_LEN : GAP_CYCLES;
  localparam int CNT_MAX  = (CNT_MAX0 > ADDR_BITS) ? CNT_MAX0 : ADDR_BITS;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);

  tx_state_e          nxt_state;
  logic [CNT_W-1:0]   nxt_idx;
  logic               nxt_take, nxt_end, accept, last_take;
  logic [3:0]         dest_q;
  logic [MAX_LEN-1:0] pay_q;
  logic [LEN_W-1:0]   len_q;

  sertx_store #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_store (
    .clk(clk), .rst(rst), .accept(accept),
    .dest_i(dest_i), .payload_i(payload_i), .len_i(len_i),
    .dest_q(dest_q), .pay_q(pay_q), .len_q(len_q)
  );

  sertx_seq #(.GAP_CYCLES(GAP_CYCLES), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .busy_ni(busy_ni), .len_q(len_q),
    .nxt_state(nxt_state), .nxt_idx(nxt_idx), .nxt_take(nxt_take),
    .nxt_end(nxt_end), .accept(accept), .last_take(last_take), .ready_o(ready_o)
  );

  sertx_oreg #(.MAX_LEN(MAX_LEN), .CNT_W(CNT_W)) u_oreg (
    .clk(clk), .rst(rst), .nxt_state(nxt_state), .nxt_idx(nxt_idx),
    .nxt_take(nxt_take), .nxt_end(nxt_end), .accept(accept),
    .dest0_i(dest_i[0]), .dest_q(dest_q), .pay_q(pay_q), .last_take(last_take),
    .frame_no(frame_no), .valid_no(valid_no), .data_o(data_o), .done_o(done_o)
  );
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic busy_ni,
  input logic ready_o,
  input logic frame_no,
  input logic valid_no,
  input logic data_o,
  input logic done_o
);
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ready_o && !done_o && frame_no && valid_no); // R1
  AST_ACCEPT_OPENS: assert property (@(posedge clk) disable iff (rst)
    start_i && ready_o |=> !frame_no && !ready_o); // R2
  AST_OPEN_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    $fell(frame_no) |-> valid_no); // R3
  AST_TAKE_NEEDS_FREE: assert property (@(posedge clk) disable iff (rst)
    !valid_no |-> $past(busy_ni)); // R5
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !frame_no && $past(!frame_no) && $past(!busy_ni) |-> valid_no); // R6
  AST_END_DONE: assert property (@(posedge clk) disable iff (rst)
    !valid_no && frame_no |=> done_o); // R8
  AST_GAP_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !ready_o && frame_no); // R9
  AST_GAP_FRAME_HIGH: assert property (@(posedge clk) disable iff (rst)
    done_o |=> frame_no && !done_o); // R9
  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> frame_no && valid_no && !data_o); // R10
endmodule

bind sertx_top sertx_chk u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .busy_ni(busy_ni),
  .ready_o(ready_o), .frame_no(frame_no), .valid_no(valid_no),
  .data_o(data_o), .done_o(done_o)
);

// File: tb/sim_sertx_top.sv
module sim_sertx_top;
  localparam int MAX_LEN = 16;
  localparam int GAP     = 1;

  typedef struct packed {
    logic [3:0]  d;
    logic [15:0] p;
    logic [4:0]  l;
    logic [31:0] pat;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{4'hA, 16'h00B5, 5'd8,  32'hFFFF_FFFF},
    '{4'h5, 16'hC3A6, 5'd16, 32'hF0F0_0F0F},
    '{4'h3, 16'h0001, 5'd1,  32'hFFFF_FF00},
    '{4'hC, 16'h8001, 5'd16, 32'h0000_FFFF},
    '{4'hF, 16'h1234, 5'd0,  32'hFFFF_FFFF},
    '{4'h6, 16'h9E37, 5'd20, 32'hFFF3_FFFF}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [3:0] dest_i = '0;
  logic [15:0] payload_i = '0;
  logic [4:0] len_i = '0;
  logic busy_ni = 1'b1;
  logic ready_o, frame_no, valid_no, data_o, done_o;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sertx_top #(.MAX_LEN(MAX_LEN), .GAP_CYCLES(GAP)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .dest_i(dest_i),
    .payload_i(payload_i), .len_i(len_i), .busy_ni(busy_ni),
    .ready_o(ready_o), .frame_no(frame_no), .valid_no(valid_no),
    .data_o(data_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_frame(input logic [3:0] d, input logic [15:0] p,
                           input logic [4:0] l, input logic [31:0] pat,
                           input bit hold);
    int eff, k;
    bit prev_busy, take, endf;
    logic [2:0] ex, pins;
    string tag;
    eff = (l == 0) ? 1 : ((l > 16) ? 16 : int'(l)); // R11
    for (int w = 0; w < 50 && !ready_o; w++) @(negedge clk);
    start_i = 1'b1; dest_i = d; payload_i = p; len_i = l; busy_ni = pat[0];
    @(negedge clk);
    chk(ready_o == 1'b0, "R2 ready after accept", ready_o, 0);
    if (hold) begin
      dest_i = ~d; payload_i = ~p; len_i = 5'd3;
    end else begin
      start_i = 1'b0;
    end
    k = 0; prev_busy = pat[0]; endf = 0;
    for (int cyc = 1; cyc < 80 && !endf; cyc++) begin
      if (cyc <= 4) begin
        ex = {1'b0, 1'b1, d[cyc-1]}; tag = "R3 address";
      end else if (cyc == 5) begin
        ex = 3'b011; tag = "R4 marker";
      end else if (cyc <= 8) begin
        ex = 3'b010; tag = "R4 pad";
      end else begin
        take = prev_busy;
        ex = {take && (k == eff - 1), ~take, p[k]};
        if (!take) tag = "R6 stall";
        else if (k == eff - 1) tag = "R7 last bit";
        else tag = "R5 payload";
        if (take) begin
          if (k == eff - 1) endf = 1;
          k++;
        end
      end
      pins = {frame_no, valid_no, data_o};
      chk(pins == ex, tag, pins, ex);
      chk(done_o == 1'b0, "R8 no early done", done_o, 0);
      busy_ni = pat[cyc % 32];
      prev_busy = busy_ni;
      @(negedge clk);
    end
    chk(endf, "R7 frame ended", endf, 1);
    busy_ni = 1'b1;
    chk(done_o == 1'b1, "R8 done pulse", done_o, 1);
    pins = {frame_no, valid_no, data_o};
    chk(pins == 3'b110, "R9 gap pins", pins, 3'b110);
    chk(ready_o == 1'b0, "R9 gap not ready", ready_o, 0);
    @(negedge clk);
    chk(done_o == 1'b0, "R8 single pulse", done_o, 0);
    pins = {frame_no, valid_no, data_o};
    chk(pins == 3'b110, "R10 idle pins", pins, 3'b110);
    chk(ready_o == 1'b1, "R9 ready after gap", ready_o, 1);
    if (hold) begin
      @(negedge clk);
      pins = {frame_no, valid_no, data_o};
      ex = {1'b0, 1'b1, ~d[0]};
      chk(pins == ex, "R9 back-to-back start", pins, ex);
    end
  endtask

  initial begin
    logic [2:0] pins;
    repeat (3) @(negedge clk);
    pins = {frame_no, valid_no, data_o};
    chk(pins == 3'b110, "R1 reset pins", pins, 3'b110);
    chk(ready_o == 1'b1 && done_o == 1'b0, "R1 reset ready/done",
        {ready_o, done_o}, 2'b10);
    rst = 1'b0;
    @(negedge clk);
    pins = {frame_no, valid_no, data_o};
    chk(pins == 3'b110, "R10 idle before start", pins, 3'b110);

    foreach (VECS[i]) run_frame(VECS[i].d, VECS[i].p, VECS[i].l, VECS[i].pat, 1'b0);

    // R2 and R9: start held high with operands changed mid-frame
    run_frame(4'h9, 16'h5A5A, 5'd6, 32'hFFFF_FFFF, 1'b1);

    // R12: reset in the middle of the frame that just opened
    start_i = 1'b0; rst = 1'b1;
    @(negedge clk);
    pins = {frame_no, valid_no, data_o};
    chk(pins == 3'b110, "R12 abort pins", pins, 3'b110);
    chk(ready_o == 1'b1 && done_o == 1'b0, "R12 abort ready/done",
        {ready_o, done_o}, 2'b10);
    rst = 1'b0;
    @(negedge clk);
    run_frame(4'h2, 16'h0F0F, 5'd9, 32'hFF7F_FFFF, 1'b0); // R12 recovery

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule